// File: doc/BRIEF.md
# Clock-Stop and Peripheral Reset Control Bank

This block is the register bank that keeps the run/stop state of every peripheral clock and the hold state of every peripheral reset line. It holds 64 clock-stop bits and 64 reset bits. Each group is split into two 32-bit words. Software reaches each word at two bus addresses: a set address and a clear address four bytes above it. Any single line can therefore be changed with one write, without a read-modify-write.

The stored bits drive the per-peripheral outputs directly. A stored reset bit is the reset output of its line. A stored clock-stop bit is turned into a clock enable. For most lines a 1 means stopped. The lines named in a design-time mask use the opposite sense, and by default that mask holds only clock line 14.

The bus is a simple single-port register bus. It has an address, a write strobe, write data, and read data that follows the address within the same cycle. The clock gating cells and the PLL or divider logic sit outside this block.

Top module: `clkrst_regbank`

## Requirements
- R1: Line index i maps to word i/32, bit i%32. Reset lines 0..31 are in the word at 0x040 and lines 32..63 in the word at 0x050. Clock lines 0..31 are in the word at 0x080 and lines 32..63 in the word at 0x090.
- R2: A write to a word's base address sets every stored bit whose write-data bit is 1.
- R3: A write to base+4 clears every stored bit whose write-data bit is 1.
- R4: These writes leave unchanged:
  - write-data bits that are 0;
  - any cycle without a write;
  - a write to an unmapped address.
- R5: `periph_rst_o[i]` equals the stored reset bit i, where 1 holds the peripheral in reset.
- R6: For clock line i, `clk_en_o[i]` is the inverse of the stored bit. The exception is line 14 (the default inverted mask 0x4000), where `clk_en_o[14]` equals the stored bit.
- R7: Read data follows `bus_addr` in the same cycle:
  - a base address returns the stored word;
  - its clear alias returns the same word;
  - any other address returns 0.
- R8: After reset, every reset bit is 1 and every clock is in its stopped state. The exception is the running mask, by default lines 0, 6 and 34. The stored clock words are then 0xFFFFBFBE at 0x080 and 0xFFFFFFFB at 0x090, and `clk_en_o` equals 0x0000000400000041.
- R9: A write changes the stored bits, the outputs and the readback at the next rising clock edge, and not before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bank clock |
| rst_n | input | 1 | Active-low reset that loads the power-on values |
| bus_addr | input | 12 | Byte address of the access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data: 1 bits select the bits to set or clear |
| bus_rdata | output | 32 | Read data for bus_addr |
| periph_rst_o | output | 64 | Per-line reset outputs, 1 = held in reset |
| clk_en_o | output | 64 | Per-line clock enables after polarity mapping |

## Verification
The outputs are the stored bits, so a wrong stored bit shows up on `periph_rst_o` or `clk_en_o` one edge after the write that caused it. The same bit shows up in the readback of either alias in the cycle its address is applied.

A swapped alias, a wrong bank index, or a word decoded at the wrong offset flips lines other than the one written. A full-vector compare after each write catches this at once. A missing polarity inversion on line 14 shows from reset, because its enable would read 1 instead of 0.

// File: rtl/crb_pkg.sv
package crb_pkg;
   // Access kind of a decoded bus address within one word.
   typedef enum logic [1:0] {
      ACC_NONE = 2'd0,
      ACC_SET  = 2'd1,
      ACC_CLR  = 2'd2
   } crb_acc_e;

   // Power-on stored value of clock words: stopped unless in the run mask.
   function automatic logic [127:0] crb_clk_por(input logic [127:0] inv_mask,
                                                input logic [127:0] run_mask);
      return ~inv_mask ^ run_mask;
   endfunction
endpackage

// File: rtl/crb_word.sv
module crb_word
   import crb_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int DATA_W    = 32,
   parameter int BASE      = 'h40,
   parameter int ALIAS_OFF = 4,
   parameter logic [DATA_W-1:0] POR_VAL = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] q,
   output logic              rd_hit
);
   localparam logic [ADDR_W-1:0] SET_A = ADDR_W'(BASE);
   localparam logic [ADDR_W-1:0] CLR_A = ADDR_W'(BASE + ALIAS_OFF);

   crb_acc_e acc;

   always_comb begin
      if (addr == SET_A)      acc = ACC_SET;
      else if (addr == CLR_A) acc = ACC_CLR;
      else                    acc = ACC_NONE;
   end

   assign rd_hit = (acc != ACC_NONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= POR_VAL;
      end else if (we) begin
         case (acc)
            ACC_SET: q <= q | wdata;
            ACC_CLR: q <= q & ~wdata;
            default: q <= q;
         endcase
      end
   end
endmodule

// File: rtl/crb_rdmux.sv
module crb_rdmux #(
   parameter int DATA_W = 32,
   parameter int NWORDS = 4
) (
   input  logic [NWORDS-1:0]             hit,
   input  logic [NWORDS-1:0][DATA_W-1:0] words,
   output logic [DATA_W-1:0]             rdata
);
   // Decodes are mutually exclusive, so an AND-OR tree is enough.
   always_comb begin
      rdata = '0;
      for (int k = 0; k < NWORDS; k++) begin
         rdata = rdata | (words[k] & {DATA_W{hit[k]}});
      end
   end
endmodule

// File: rtl/crb_polarity.sv
module crb_polarity #(
   parameter int WIDTH = 64,
   parameter logic [WIDTH-1:0] INV_MASK = '0
) (
   input  logic [WIDTH-1:0] stop_q,
   output logic [WIDTH-1:0] en
);
   for (genvar i = 0; i < WIDTH; i++) begin : g_line
      if (INV_MASK[i]) begin : g_direct
         assign en[i] = stop_q[i];
      end else begin : g_negate
         assign en[i] = ~stop_q[i];
      end
   end
endmodule

// File: rtl/clkrst_regbank.sv
module clkrst_regbank
   import crb_pkg::*;
#(
   parameter int ADDR_W      = 12,
   parameter int DATA_W      = 32,
   parameter int BANKS       = 2,
   parameter int RST_BASE    = 'h040,
   parameter int CLK_BASE    = 'h080,
   parameter int BANK_STRIDE = 'h10,
   parameter int ALIAS_OFF   = 4,
   parameter logic [BANKS*DATA_W-1:0] CLK_INV_MASK = 64'h0000_0000_0000_4000,
   parameter logic [BANKS*DATA_W-1:0] CLK_RUN_MASK = 64'h0000_0004_0000_0041
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [ADDR_W-1:0]       bus_addr,
   input  logic                    bus_we,
   input  logic [DATA_W-1:0]       bus_wdata,
   output logic [DATA_W-1:0]       bus_rdata,
   output logic [BANKS*DATA_W-1:0] periph_rst_o,
   output logic [BANKS*DATA_W-1:0] clk_en_o
);
   localparam int LINES  = BANKS * DATA_W;
   localparam int NWORDS = 2 * BANKS;
   localparam int SPAN   = BANKS * BANK_STRIDE;
   localparam logic [127:0] CLK_POR =
      crb_clk_por(128'(CLK_INV_MASK), 128'(CLK_RUN_MASK));

   // Elaboration-time parameter checks
   if (ALIAS_OFF <= 0 || ALIAS_OFF >= BANK_STRIDE) begin : g_bad_alias
      $error("alias offset must lie inside one bank stride");
   end
   if (ALIAS_OFF % 4 != 0 || BANK_STRIDE % 4 != 0) begin : g_bad_align
      $error("alias offset and stride must be word aligned");
   end
   if (!((RST_BASE + SPAN <= CLK_BASE) || (CLK_BASE + SPAN <= RST_BASE))) begin : g_overlap
      $error("reset and clock word ranges overlap");
   end
   if (RST_BASE + SPAN > (1 << ADDR_W) || CLK_BASE + SPAN > (1 << ADDR_W)) begin : g_range
      $error("word ranges exceed the address width");
   end
   if (LINES > 128) begin : g_too_wide
      $error("at most 128 lines per group");
   end

   logic [NWORDS-1:0]             hit;
   logic [NWORDS-1:0][DATA_W-1:0] words;
   logic [LINES-1:0]              rst_q;
   logic [LINES-1:0]              stop_q;

   for (genvar b = 0; b < BANKS; b++) begin : g_bank
      crb_word #(
         .ADDR_W   (ADDR_W),
         .DATA_W   (DATA_W),
         .BASE     (RST_BASE + b * BANK_STRIDE),
         .ALIAS_OFF(ALIAS_OFF),
         .POR_VAL  ({DATA_W{1'b1}})
      ) u_rst (
         .clk   (clk),
         .rst_n (rst_n),
         .addr  (bus_addr),
         .we    (bus_we),
         .wdata (bus_wdata),
         .q     (rst_q[b*DATA_W +: DATA_W]),
         .rd_hit(hit[b])
      );

      crb_word #(
         .ADDR_W   (ADDR_W),
         .DATA_W   (DATA_W),
         .BASE     (CLK_BASE + b * BANK_STRIDE),
         .ALIAS_OFF(ALIAS_OFF),
         .POR_VAL  (CLK_POR[b*DATA_W +: DATA_W])
      ) u_clk (
         .clk   (clk),
         .rst_n (rst_n),
         .addr  (bus_addr),
         .we    (bus_we),
         .wdata (bus_wdata),
         .q     (stop_q[b*DATA_W +: DATA_W]),
         .rd_hit(hit[BANKS + b])
      );

      assign words[b]         = rst_q[b*DATA_W +: DATA_W];
      assign words[BANKS + b] = stop_q[b*DATA_W +: DATA_W];
   end

   crb_rdmux #(
      .DATA_W(DATA_W),
      .NWORDS(NWORDS)
   ) u_rdmux (
      .hit  (hit),
      .words(words),
      .rdata(bus_rdata)
   );

   crb_polarity #(
      .WIDTH   (LINES),
      .INV_MASK(CLK_INV_MASK)
   ) u_pol (
      .stop_q(stop_q),
      .en    (clk_en_o)
   );

   assign periph_rst_o = rst_q;
endmodule

// File: rtl/crb_checker.sv
module crb_checker #(
   parameter int ADDR_W      = 12,
   parameter int DATA_W      = 32,
   parameter int BANKS       = 2,
   parameter int RST_BASE    = 'h040,
   parameter int CLK_BASE    = 'h080,
   parameter int BANK_STRIDE = 'h10,
   parameter int ALIAS_OFF   = 4,
   parameter logic [BANKS*DATA_W-1:0] CLK_INV_MASK = '0
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic [ADDR_W-1:0]       bus_addr,
   input logic                    bus_we,
   input logic [DATA_W-1:0]       bus_wdata,
   input logic [DATA_W-1:0]       bus_rdata,
   input logic [BANKS*DATA_W-1:0] periph_rst_o,
   input logic [BANKS*DATA_W-1:0] clk_en_o
);
   localparam logic [ADDR_W-1:0] R0_SET = ADDR_W'(RST_BASE);
   localparam logic [ADDR_W-1:0] R0_CLR = ADDR_W'(RST_BASE + ALIAS_OFF);
   localparam logic [ADDR_W-1:0] C0_SET = ADDR_W'(CLK_BASE);
   localparam logic [DATA_W-1:0] INV0   = CLK_INV_MASK[DATA_W-1:0];

   logic mapped;
   always_comb begin
      mapped = 1'b0;
      for (int b = 0; b < BANKS; b++) begin
         if (bus_addr == ADDR_W'(RST_BASE + b*BANK_STRIDE) ||
             bus_addr == ADDR_W'(RST_BASE + b*BANK_STRIDE + ALIAS_OFF) ||
             bus_addr == ADDR_W'(CLK_BASE + b*BANK_STRIDE) ||
             bus_addr == ADDR_W'(CLK_BASE + b*BANK_STRIDE + ALIAS_OFF))
            mapped = 1'b1;
      end
   end

   assert_set_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == R0_SET) |=>
      ((periph_rst_o[DATA_W-1:0] & $past(bus_wdata)) == $past(bus_wdata)));

   assert_clear_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == R0_CLR) |=>
      ((periph_rst_o[DATA_W-1:0] & $past(bus_wdata)) == '0));

   assert_keep_zero_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == R0_SET) |=>
      ((periph_rst_o[DATA_W-1:0] & ~$past(bus_wdata)) ==
       ($past(periph_rst_o[DATA_W-1:0]) & ~$past(bus_wdata))));

   assert_idle_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_we |=> ($stable(periph_rst_o) && $stable(clk_en_o)));

   assert_polarity_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == C0_SET) |=>
      (((clk_en_o[DATA_W-1:0] & $past(bus_wdata) & INV0) == ($past(bus_wdata) & INV0)) &&
       ((clk_en_o[DATA_W-1:0] & $past(bus_wdata) & ~INV0) == '0)));

   assert_unmapped_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !mapped |-> (bus_rdata == '0));

   assert_alias_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == R0_CLR) |-> (bus_rdata == periph_rst_o[DATA_W-1:0]));
endmodule

bind clkrst_regbank crb_checker #(
   .ADDR_W      (ADDR_W),
   .DATA_W      (DATA_W),
   .BANKS       (BANKS),
   .RST_BASE    (RST_BASE),
   .CLK_BASE    (CLK_BASE),
   .BANK_STRIDE (BANK_STRIDE),
   .ALIAS_OFF   (ALIAS_OFF),
   .CLK_INV_MASK(CLK_INV_MASK)
) u_crb_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_addr    (bus_addr),
   .bus_we      (bus_we),
   .bus_wdata   (bus_wdata),
   .bus_rdata   (bus_rdata),
   .periph_rst_o(periph_rst_o),
   .clk_en_o    (clk_en_o)
);

// File: tb/tb_clkrst_regbank.sv
`timescale 1ns/1ps
module tb_clkrst_regbank;
   localparam logic [63:0] INV = 64'h0000_0000_0000_4000;  // R6

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [63:0] periph_rst_o;
   logic [63:0] clk_en_o;

   int checks = 0;
   int errors = 0;
   logic [63:0] rst_m;   // expected stored reset bits
   logic [63:0] clk_m;   // expected stored clock-stop bits

   always #2 clk = ~clk;  // 250 MHz

   clkrst_regbank dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .periph_rst_o(periph_rst_o), .clk_en_o(clk_en_o)
   );

   task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   function automatic logic [63:0] en_of(input logic [63:0] s);
      return s ^ ~INV;
   endfunction

   task automatic check_outputs(input string req);
      chk(req, periph_rst_o, rst_m);
      chk(req, clk_en_o, en_of(clk_m));
   endtask

   function automatic logic [31:0] word_of(input logic [11:0] a);
      case (a)
         12'h040, 12'h044: return rst_m[31:0];
         12'h050, 12'h054: return rst_m[63:32];
         12'h080, 12'h084: return clk_m[31:0];
         12'h090, 12'h094: return clk_m[63:32];
         default:          return 32'h0;
      endcase
   endfunction

   task automatic bus_read(input logic [11:0] a, input string req);
      @(negedge clk);
      bus_addr = a;
      #1;
      chk(req, {32'h0, bus_rdata}, {32'h0, word_of(a)});
   endtask

   // Write, checking outputs stay put before the edge (R9) and move after it.
   task automatic bus_write(input logic [11:0] a, input logic [31:0] d, input string req);
      @(negedge clk);
      bus_addr = a; bus_we = 1'b1; bus_wdata = d;
      #1;
      check_outputs("R9 before edge");
      case (a)
         12'h040: rst_m[31:0]  = rst_m[31:0]  | d;
         12'h044: rst_m[31:0]  = rst_m[31:0]  & ~d;
         12'h050: rst_m[63:32] = rst_m[63:32] | d;
         12'h054: rst_m[63:32] = rst_m[63:32] & ~d;
         12'h080: clk_m[31:0]  = clk_m[31:0]  | d;
         12'h084: clk_m[31:0]  = clk_m[31:0]  & ~d;
         12'h090: clk_m[63:32] = clk_m[63:32] | d;
         12'h094: clk_m[63:32] = clk_m[63:32] & ~d;
         default: ;
      endcase
      @(negedge clk);
      bus_we = 1'b0; bus_wdata = '0;
      #1;
      check_outputs(req);
   endtask

   task automatic t_reset_state;
      rst_m = '1;
      clk_m = {32'hFFFF_FFFB, 32'hFFFF_BFBE};
      check_outputs("R8 por outputs");
      chk("R8 por clk_en", clk_en_o, 64'h0000_0004_0000_0041);
      chk("R5 por reset", periph_rst_o, '1);
      bus_read(12'h040, "R8 read 040");
      bus_read(12'h050, "R8 read 050");
      bus_read(12'h080, "R8 read 080");
      bus_read(12'h090, "R8 read 090");
   endtask

   task automatic t_reset_bank;
      bus_write(12'h044, 32'h0000_00F0, "R3 clear rst low");
      bus_read(12'h040, "R7 base read");
      bus_read(12'h044, "R7 alias read");
      bus_write(12'h054, 32'h0000_0100, "R1 clear rst line 40");
      chk("R1 rst line 40", {63'h0, periph_rst_o[40]}, 64'h0);
      chk("R5 rst line 39", {63'h0, periph_rst_o[39]}, 64'h1);
      bus_write(12'h040, 32'h0000_0030, "R2 set rst bits 4 5");
      bus_write(12'h040, 32'h0000_0000, "R4 zero write");
      bus_read(12'h054, "R7 alias read bank1");
   endtask

   task automatic t_clock_bank;
      bus_write(12'h084, 32'h0000_0002, "R6 clear clk line 1");
      chk("R6 clk line 1 runs", {63'h0, clk_en_o[1]}, 64'h1);
      bus_write(12'h084, 32'h0000_4000, "R6 clear inverted line 14");
      chk("R6 line 14 stopped", {63'h0, clk_en_o[14]}, 64'h0);
      bus_write(12'h080, 32'h0000_4000, "R6 set inverted line 14");
      chk("R6 line 14 runs", {63'h0, clk_en_o[14]}, 64'h1);
      bus_write(12'h080, 32'h0000_0002, "R2 set clk line 1");
      bus_write(12'h094, 32'h4000_0000, "R1 clear clk line 62");
      chk("R1 clk line 62 runs", {63'h0, clk_en_o[62]}, 64'h1);
      bus_read(12'h090, "R7 read 090");
   endtask

   task automatic t_unmapped;
      bus_read(12'h048, "R7 unmapped 048");
      bus_read(12'h000, "R7 unmapped 000");
      bus_read(12'h042, "R7 unmapped 042");
      bus_write(12'h048, 32'hFFFF_FFFF, "R4 unmapped set");
      bus_write(12'h08C, 32'hFFFF_FFFF, "R4 unmapped clear");
      bus_read(12'h040, "R4 rst low kept");
      bus_read(12'h084, "R4 clk low kept");
   endtask

   initial begin
      #(4 * 100000);
      errors++;
      $display("FAIL watchdog expired got=hung exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      t_reset_state;
      t_reset_bank;
      t_clock_bank;
      t_unmapped;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule